// File: doc/BRIEF.md
# Asynchronous SRAM Bridge

This block lets synchronous logic on a single clock read and write an external static RAM that has no clock of its own. The RAM has 18 address bits and 16 data bits split into a lower and an upper byte. A client presents one request at a time: a strobe, a write flag, an address, write data and two byte-enable bits. The bridge then drives the RAM's active-low chip enable, write enable, output enable and the two byte strobes. It presents the bidirectional data pins as three separate signals: data out, a drive enable and data in. When the access completes, it raises a one-cycle done pulse. Reads return their data on the same cycle as done.

All analog timing limits are met by counting clock cycles. Two parameters set this: the clock period in nanoseconds and the RAM's speed grade, which is 55 ns or 70 ns. Every minimum time is converted to a cycle count and rounded up. Each write has three parts. A setup cycle settles the address, the strobes and the data. Write enable then stays low for a stretched pulse. A hold cycle follows, during which the address and data do not move. Each read keeps output enable low for the access window, captures the data on the last cycle of that window, and then deselects the RAM for a turnaround period so that the bus is released before the bridge can drive it again.

Top module: `asyncSramCtrl`

## Requirements
- R1: The address is 18 bits and a word is 16 bits; a word written at any address, including 0x00000 and 0x3FFFF, reads back unchanged while other addresses keep their own contents.
- R2: In reset, and until the first request, chip enable, write enable, output enable and both byte strobes are high, the data drive enable and done are low, and reqReady is high.
- R3: reqBe bit 0 enables the lower strobe, which gates data bits 7:0, and reqBe bit 1 enables the upper strobe, which gates bits 15:8. A write changes only the enabled bytes, and a write with reqBe = 00 changes nothing. A byte strobe is low only while chip enable is low.
- R4: On a read, rdData carries the RAM's bytes for the enabled lanes and zero in the bits of any disabled lane.
- R5: A read holds chip enable and output enable low and write enable high for RC = ceil(max(tAA, tOE) / T) + 1 cycles. Here T is the clock period, tAA is 55 ns and tOE is 30 ns at the 55 ns grade. done and rdData appear RC rising edges after the edge that accepts the request.
- R6: A write uses 1 setup cycle, then P cycles with write enable low, then 1 hold cycle, where P = max(ceil(tWP/T), ceil(tDW/T), ceil(tWC/T) - 1). At the 55 ns grade tWP is 30 ns, tDW is 25 ns and tWC is 55 ns. The result is a write pulse of at least 30 ns, data stable at least 25 ns before write enable rises, and at least 55 ns from a valid address and chip enable to the end of the write. Address and data do not change on the edge that ends the write. done appears 2 + P edges after the accepting edge.
- R7: Write enable is high in every cycle in which the address changes, and in the cycle before it.
- R8: Output enable stays high throughout a write. The bridge drives the data bus only while output enable is high and only once output enable has been high for at least H = ceil(tOHZ/T) cycles, where tOHZ is 25 ns at the 55 ns grade. Every read is followed by H deselected cycles.
- R9: done is high for exactly one cycle, once for each accepted request.
- R10: reqReady is high only when the bridge is idle, and it falls on the cycle after a request is accepted. A request presented while reqReady is low is ignored: it gives no done pulse and no change to the RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, bit 0 lower byte, bit 1 upper byte |
| reqReady | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read data, valid while done is high after a read |
| sramAddr | output | 18 | RAM address |
| sramCeN | output | 1 | Chip enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramLbN | output | 1 | Lower byte strobe, active low |
| sramUbN | output | 1 | Upper byte strobe, active low |
| sramDqOut | output | 16 | Data toward the RAM |
| sramDqOe | output | 1 | Drive enable for sramDqOut |
| sramDqIn | input | 16 | Data from the RAM |

## Verification
The bound checker watches the pin-level rules on every cycle. These are: write enable high around every address change, write enable low only with the chip selected and output enable high, no drive while output enable is low, the high-impedance wait before driving, strobes only under chip enable, done as a single pulse, and reqReady falling after each accept. Some properties need an actual RAM to observe, and only the bench's scenarios can show them. These are byte-lane merging in storage, zeroing of disabled read lanes, the latencies in cycles, and the nanosecond windows measured against a RAM model, which covers pulse width, data setup, address-to-end time and the read access time. The same holds for dropping requests that arrive while the bridge is busy.

// File: rtl/asyncSramPkg.sv
`timescale 1ns/1ps
package asyncSramPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_HIZ,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } ctrlStateT;

  // Pin levels registered from the next state, plus datapath strobes.
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic laneOn;
    logic driveData;
  } pinSetT;

  typedef struct packed {
    logic loadReq;   // latch the request into the datapath
    logic capture;   // sample the RAM data on this edge
    logic finish;    // raise done on the next cycle
    logic laneOn;    // byte strobes may follow the byte enables
    logic driveData; // drive the data bus
  } ctrlStrobeT;

  typedef enum logic [2:0] {
    TK_ADDR_ACCESS,
    TK_OE_ACCESS,
    TK_OE_HIZ,
    TK_WR_CYCLE,
    TK_WR_PULSE,
    TK_DATA_SETUP
  } timingKindT;

  function automatic int unsigned gradeNs(input int unsigned speedNs, input timingKindT kind);
    int unsigned v;
    if (speedNs <= 55) begin
      case (kind)
        TK_ADDR_ACCESS: v = 55;
        TK_OE_ACCESS:   v = 30;
        TK_OE_HIZ:      v = 25;
        TK_WR_CYCLE:    v = 55;
        TK_WR_PULSE:    v = 30;
        default:        v = 25;
      endcase
    end else begin
      case (kind)
        TK_ADDR_ACCESS: v = 70;
        TK_OE_ACCESS:   v = 35;
        TK_OE_HIZ:      v = 30;
        TK_WR_CYCLE:    v = 70;
        TK_WR_PULSE:    v = 35;
        default:        v = 30;
      endcase
    end
    return v;
  endfunction

  function automatic int unsigned ceilDiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic pinSetT pinsFor(input ctrlStateT s);
    pinSetT p;
    p = '{ceN: 1'b1, weN: 1'b1, oeN: 1'b1, laneOn: 1'b0, driveData: 1'b0};
    case (s)
      ST_RD_ACC: begin
        p.ceN = 1'b0; p.oeN = 1'b0; p.laneOn = 1'b1;
      end
      ST_WR_SETUP, ST_WR_HOLD: begin
        p.ceN = 1'b0; p.laneOn = 1'b1; p.driveData = 1'b1;
      end
      ST_WR_PULSE: begin
        p.ceN = 1'b0; p.weN = 1'b0; p.laneOn = 1'b1; p.driveData = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/asyncSramFsm.sv
`timescale 1ns/1ps
module asyncSramFsm
  import asyncSramPkg::*;
#(
  parameter int unsigned RD_CYCLES       = 7,
  parameter int unsigned WR_PULSE_CYCLES = 5,
  parameter int unsigned HIZ_CYCLES      = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       ceN,
  output logic       weN,
  output logic       oeN,
  output ctrlStrobeT strobe
);

  localparam int unsigned LONGEST = maxOf(maxOf(RD_CYCLES, WR_PULSE_CYCLES), HIZ_CYCLES);
  localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_CYCLES - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(WR_PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] HIZ_LAST   = CNT_W'(HIZ_CYCLES - 1);

  ctrlStateT        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  pinSetT           pinsQ;
  logic             loadReq, capture, finish;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pinsQ <= pinsFor(ST_IDLE);
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      pinsQ <= pinsFor(nextState);
    end
  end

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    loadReq   = 1'b0;
    capture   = 1'b0;
    finish    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          loadReq   = 1'b1;
          nextCnt   = '0;
          nextState = reqWrite ? ST_WR_SETUP : ST_RD_ACC;
        end
      end
      ST_RD_ACC: begin
        if (cnt == RD_LAST) begin
          capture   = 1'b1;
          finish    = 1'b1;
          nextCnt   = '0;
          nextState = ST_RD_HIZ;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_RD_HIZ: begin
        if (cnt == HIZ_LAST) begin
          nextCnt   = '0;
          nextState = ST_IDLE;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_WR_SETUP: begin
        nextCnt   = '0;
        nextState = ST_WR_PULSE;
      end
      ST_WR_PULSE: begin
        if (cnt == PULSE_LAST) begin
          nextCnt   = '0;
          nextState = ST_WR_HOLD;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_WR_HOLD: begin
        finish    = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign ceN      = pinsQ.ceN;
  assign weN      = pinsQ.weN;
  assign oeN      = pinsQ.oeN;

  assign strobe = '{loadReq: loadReq, capture: capture, finish: finish,
                    laneOn: pinsQ.laneOn, driveData: pinsQ.driveData};

endmodule

// File: rtl/asyncSramPath.sv
`timescale 1ns/1ps
module asyncSramPath
  import asyncSramPkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] dqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [LANES-1:0]  laneN,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  localparam int unsigned LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] rdMasked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      rdData <= '0;
      done   <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqBe;
      end
      if (strobe.capture) begin
        rdData <= rdMasked;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneN[g] = ~(strobe.laneOn & beQ[g]);
    assign rdMasked[g*LANE_W +: LANE_W] = beQ[g] ? dqIn[g*LANE_W +: LANE_W] : '0;
  end

  assign sramAddr = addrQ;
  assign dqOut    = wdataQ;
  assign dqOe     = strobe.driveData;

endmodule

// File: rtl/asyncSramCtrl.sv
`timescale 1ns/1ps
module asyncSramCtrl
  import asyncSramPkg::*;
#(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SPEED_NS      = 55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqBe,
  output logic              reqReady,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              sramLbN,
  output logic              sramUbN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int unsigned ACCESS_NS =
    maxOf(gradeNs(SPEED_NS, TK_ADDR_ACCESS), gradeNs(SPEED_NS, TK_OE_ACCESS));
  // One extra cycle of margin for the capturing flop.
  localparam int unsigned RD_CYCLES = ceilDiv(ACCESS_NS, CLK_PERIOD_NS) + 1;
  localparam int unsigned WR_PULSE_CYCLES =
    maxOf(maxOf(ceilDiv(gradeNs(SPEED_NS, TK_WR_PULSE), CLK_PERIOD_NS),
                ceilDiv(gradeNs(SPEED_NS, TK_DATA_SETUP), CLK_PERIOD_NS)),
          ceilDiv(gradeNs(SPEED_NS, TK_WR_CYCLE), CLK_PERIOD_NS) - 1);
  localparam int unsigned HIZ_CYCLES = ceilDiv(gradeNs(SPEED_NS, TK_OE_HIZ), CLK_PERIOD_NS);

  ctrlStrobeT strobe;
  logic [1:0] laneN;

  asyncSramFsm #(
    .RD_CYCLES      (RD_CYCLES),
    .WR_PULSE_CYCLES(WR_PULSE_CYCLES),
    .HIZ_CYCLES     (HIZ_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .ceN     (sramCeN),
    .weN     (sramWeN),
    .oeN     (sramOeN),
    .strobe  (strobe)
  );

  asyncSramPath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (2)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqBe   (reqBe),
    .dqIn    (sramDqIn),
    .sramAddr(sramAddr),
    .dqOut   (sramDqOut),
    .dqOe    (sramDqOe),
    .laneN   (laneN),
    .rdData  (rdData),
    .done    (done)
  );

  assign sramLbN = laneN[0];
  assign sramUbN = laneN[1];

endmodule

// File: rtl/asyncSramChecker.sv
`timescale 1ns/1ps
module asyncSramChecker #(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned HIZ_CYCLES = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              done,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramCeN,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic              sramLbN,
  input logic              sramUbN,
  input logic              sramDqOe
);

  localparam int unsigned HC_W = $clog2(HIZ_CYCLES + 1);

  // Cycles that output enable has been high, saturating at HIZ_CYCLES.
  logic [HC_W-1:0] hizCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hizCnt <= HC_W'(HIZ_CYCLES);
    else if (!sramOeN) hizCnt <= '0;
    else if (hizCnt < HC_W'(HIZ_CYCLES)) hizCnt <= hizCnt + 1'b1;
  end

  // R3
  lane_needs_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramLbN || !sramUbN) |-> !sramCeN);

  // R7
  addr_move_we_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sramAddr) |-> (sramWeN && $past(sramWeN)));

  // R8
  write_oe_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (!sramCeN && sramOeN));

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> sramOeN);

  // R8
  hiz_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDqOe) |-> (hizCnt >= HC_W'(HIZ_CYCLES)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind asyncSramCtrl asyncSramChecker #(
  .ADDR_W    (ADDR_W),
  .HIZ_CYCLES(HIZ_CYCLES)
) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .done    (done),
  .sramAddr(sramAddr),
  .sramCeN (sramCeN),
  .sramWeN (sramWeN),
  .sramOeN (sramOeN),
  .sramLbN (sramLbN),
  .sramUbN (sramUbN),
  .sramDqOe(sramDqOe)
);

// File: tb/asyncSramCtrl_bench.sv
`timescale 1ns/1ps
module asyncSramCtrl_bench;

  localparam int T = 5;
  // 55 ns grade limits in ns.
  localparam int ACC_NS = 55;
  localparam int OEA_NS = 30;
  localparam int HIZ_NS = 25;
  localparam int CYC_NS = 55;
  localparam int WP_NS  = 30;
  localparam int DW_NS  = 25;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_LAT = cdiv(imax(ACC_NS, OEA_NS), T) + 1;
  localparam int WR_P   = imax(imax(cdiv(WP_NS, T), cdiv(DW_NS, T)), cdiv(CYC_NS, T) - 1);
  localparam int WR_LAT = 2 + WR_P;

  logic        clk, rstN;
  logic        reqValid, reqWrite;
  logic [17:0] reqAddr;
  logic [15:0] reqWdata;
  logic [1:0]  reqBe;
  logic        reqReady, done;
  logic [15:0] rdData;
  logic [17:0] sramAddr;
  logic        sramCeN, sramWeN, sramOeN, sramLbN, sramUbN, sramDqOe;
  logic [15:0] sramDqOut;
  logic [15:0] ramDq;

  asyncSramCtrl #(
    .ADDR_W(18), .DATA_W(16), .CLK_PERIOD_NS(T), .SPEED_NS(55)
  ) u_asyncSramCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .reqReady(reqReady), .done(done), .rdData(rdData),
    .sramAddr(sramAddr), .sramCeN(sramCeN), .sramWeN(sramWeN),
    .sramOeN(sramOeN), .sramLbN(sramLbN), .sramUbN(sramUbN),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(ramDq)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int cycleCnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // ---------------- RAM model ----------------
  logic [15:0] ram [logic [17:0]];

  function automatic logic [15:0] initWord(input logic [17:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hA5};
  endfunction
  function automatic logic [15:0] ramRead(input logic [17:0] a);
    return ram.exists(a) ? ram[a] : initWord(a);
  endfunction

  logic [17:0] pAddr;
  logic        pCe = 1'b1, pWe = 1'b1, pOe = 1'b1, pLb = 1'b1, pUb = 1'b1, pDqOe = 1'b0;
  logic [15:0] pDqOut;
  realtime tAddr = -1000.0, tCeFall = -1000.0, tOeFall = -1000.0;
  realtime tOeRise = -1000.0, tWrStart = -1000.0, tData = -1000.0;

  task automatic modelStep();
    realtime now;
    bit dataChg, wrNow, wrPrev, valid;
    logic [15:0] w;
    now = $realtime;
    if (rstN) begin
      dataChg = (sramDqOut != pDqOut) || (sramDqOe != pDqOe);
      if (sramAddr != pAddr) begin
        // R7: address may move only with write enable high
        chk(sramWeN && pWe, "R7", "address moved with WE low", {30'd0, pWe, sramWeN}, 32'h3);
        tAddr = now;
      end
      if (!sramCeN && pCe) tCeFall = now;
      if (!sramOeN && pOe) tOeFall = now;
      if (sramOeN && !pOe) tOeRise = now;
      if (sramDqOe && !pDqOe)
        chk(sramOeN && (now - tOeRise >= HIZ_NS), "R8", "drive before OE high-Z time",
            int'(now - tOeRise), HIZ_NS);
      if (sramDqOe && !sramOeN && !sramCeN)
        chk(0, "R8", "bus contention", {31'd0, sramDqOe}, 32'h0);
      wrNow  = !sramCeN && !sramWeN;
      wrPrev = !pCe && !pWe;
      if (wrNow && !wrPrev) begin
        tWrStart = now;
        chk(sramOeN, "R8", "OE low at write start", {31'd0, sramOeN}, 32'h1);
      end
      if (!wrNow && wrPrev) begin
        chk(now - tWrStart >= WP_NS, "R6", "write pulse ns", int'(now - tWrStart), WP_NS);
        chk(!dataChg && pDqOe && (now - tData >= DW_NS), "R6", "data setup/hold ns",
            dataChg ? 0 : int'(now - tData), DW_NS);
        chk(now - ((tAddr > tCeFall) ? tAddr : tCeFall) >= CYC_NS, "R6",
            "address/CE to end of write ns",
            int'(now - ((tAddr > tCeFall) ? tAddr : tCeFall)), CYC_NS);
        w = ramRead(pAddr);
        if (!pLb) w[7:0]  = pDqOut[7:0];
        if (!pUb) w[15:8] = pDqOut[15:8];
        ram[pAddr] = w;
      end
      if (dataChg) tData = now;
    end
    // output side
    ramDq = 16'hEEEE;
    if (rstN && !sramCeN && !sramOeN && sramWeN) begin
      valid = (now - ((tAddr > tCeFall) ? tAddr : tCeFall) >= ACC_NS) && (now - tOeFall >= OEA_NS);
      w = ramRead(sramAddr);
      if (valid && !sramLbN) ramDq[7:0]  = w[7:0];
      if (valid && !sramUbN) ramDq[15:8] = w[15:8];
    end
    pAddr = sramAddr; pCe = sramCeN; pWe = sramWeN; pOe = sramOeN;
    pLb = sramLbN; pUb = sramUbN; pDqOut = sramDqOut; pDqOe = sramDqOe;
  endtask

  initial begin
    ramDq = 16'hEEEE;
    #0.25;
    forever begin
      modelStep();
      #0.5;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic        wr;
    logic [15:0] exp;
    logic [31:0] acc;
  } itemT;
  itemT expQ[$];
  logic [15:0] shadow [logic [17:0]];

  function automatic logic [15:0] shadowRead(input logic [17:0] a);
    return shadow.exists(a) ? shadow[a] : initWord(a);
  endfunction

  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    itemT it;
    logic [15:0] w;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    w = shadowRead(a);
    if (wr) begin
      // R3: bit 0 -> bits 7:0, bit 1 -> bits 15:8
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      shadow[a] = w;
      it.exp = 16'h0;
    end else begin
      // R4: disabled lanes read as zero
      it.exp = {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    end
    it.wr  = wr;
    it.acc = cycleCnt + 1;
    expQ.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  always @(negedge clk) begin
    itemT it;
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        chk(0, "R9", "done without a request", 32'h1, 32'h0);
      end else begin
        it = expQ.pop_front();
        if (it.wr) begin
          chk(cycleCnt - it.acc == WR_LAT, "R6", "write latency", cycleCnt - it.acc, WR_LAT);
        end else begin
          chk(cycleCnt - it.acc == RD_LAT, "R5", "read latency", cycleCnt - it.acc, RD_LAT);
          chk(rdData == it.exp, "R1/R3/R4", "read data", rdData, it.exp);
        end
      end
    end
  end

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * T);
    checks++;
    failures++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", expQ.size(), 0);
    finishRun();
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqAddr = '0; reqWdata = '0; reqBe = '0;
    repeat (4) @(negedge clk);
    // R2: reset state
    chk(sramCeN && sramWeN && sramOeN, "R2", "control pins in reset",
        {29'd0, sramCeN, sramWeN, sramOeN}, 32'h7);
    chk(sramLbN && sramUbN, "R2", "byte strobes in reset", {30'd0, sramUbN, sramLbN}, 32'h3);
    chk(!sramDqOe && !done, "R2", "drive/done in reset", {30'd0, sramDqOe, done}, 32'h0);
    chk(reqReady, "R2", "ready in reset", {31'd0, reqReady}, 32'h1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(sramCeN && sramWeN && sramOeN && !sramDqOe, "R2", "idle pins after reset",
        {28'd0, sramCeN, sramWeN, sramOeN, sramDqOe}, 32'he);

    // R1/R3: full word then per-lane writes
    issue(1, 18'h00010, 16'h1234, 2'b11);
    issue(0, 18'h00010, 16'h0, 2'b11);
    // R5: read pins right after accept
    chk(!sramCeN && !sramOeN && sramWeN, "R5", "read pin levels",
        {29'd0, sramCeN, sramWeN, sramOeN}, 32'h2);
    issue(1, 18'h00010, 16'hABCD, 2'b01);
    issue(0, 18'h00010, 16'h0, 2'b11);
    issue(1, 18'h00010, 16'h55AA, 2'b10);
    issue(0, 18'h00010, 16'h0, 2'b11);
    // R3: lower strobe only during a lower-byte write
    issue(1, 18'h00011, 16'hC3C3, 2'b01);
    chk(!sramLbN && sramUbN && sramOeN, "R3", "lane strobes lower-only write",
        {29'd0, sramLbN, sramUbN, sramOeN}, 32'h3);
    // R4: single-lane reads
    issue(0, 18'h00010, 16'h0, 2'b01);
    issue(0, 18'h00010, 16'h0, 2'b10);
    // R3: no lanes enabled changes nothing
    issue(1, 18'h00010, 16'hFFFF, 2'b00);
    issue(0, 18'h00010, 16'h0, 2'b11);
    // R1: address extremes and an unwritten word
    issue(1, 18'h3FFFF, 16'hBEEF, 2'b11);
    issue(1, 18'h00000, 16'h0F0F, 2'b11);
    issue(0, 18'h3FFFF, 16'h0, 2'b11);
    issue(0, 18'h00000, 16'h0, 2'b11);
    issue(0, 18'h2A5A5, 16'h0, 2'b11);
    drain();

    // R10: requests while busy are dropped
    issue(1, 18'h00222, 16'h7777, 2'b11);
    chk(!reqReady, "R10", "ready while busy", {31'd0, reqReady}, 32'h0);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00333; reqWdata = 16'h9999; reqBe = 2'b11;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    drain();
    issue(0, 18'h00333, 16'h0, 2'b11);
    issue(0, 18'h00222, 16'h0, 2'b11);
    drain();

    // R9: back-to-back mixed traffic
    for (int i = 0; i < 12; i++) begin
      issue(1, 18'(18'h01000 + i * 18'h00777), 16'(16'h1111 * (i + 1)), 2'(i % 4));
      issue(0, 18'(18'h01000 + i * 18'h00777), 16'h0, 2'(3 - (i % 3)));
    end
    drain();
    chk(expQ.size() == 0, "R9", "one done per request", expQ.size(), 0);
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule